// File: doc/BRIEF.md
# ADC start and tracking sequencer

This block is the control state machine that sits in front of a successive-approximation converter. It decides when a conversion starts and drives the sample switch around it. One of four start sources is chosen at run time: a software write to the busy bit, a rising edge on an external start pin, a timer-1 overflow pulse, or a timer-2 overflow pulse. For timer 2, the overflow of the low byte or the high byte is used, depending on the timer's width mode. The converter itself is modelled only by a start strobe going out and a done/data handshake coming back.

Once a start is accepted, the sequencer runs the track, hold and convert phases under one of three tracking policies. In the pre-tracking policy the sample switch is closed whenever the converter is idle, and conversion starts at once. In the post-tracking policy a hardware-timed tracking window opens on the start, and the switch stays open after conversion. The dual-tracking policy also has the timed window, but the switch closes again after conversion. On completion the busy flag drops, the completion flag is set, the result is latched and an interrupt request is raised when interrupts are enabled.

Top module: `adc_trk_seq`

## Requirements
- R1: `start_src_i` selects the only accepted start source: 00 a `sw_busy_wr_i` pulse, 01 a rising edge of `cnv_pin_i`, 10 a `t1_ovf_i` pulse, 11 timer-2 overflow. Events from unselected sources are ignored. The pin passes through a two-flop synchronizer and an edge detector, so a pin rise set up before clock edge a is acted on at edge a+2.
- R2: With source 11, `t2_lo_ovf_i` is the event when `t2_byte_mode_i` is 1 (8-bit timer), and `t2_hi_ovf_i` is the event when it is 0 (16-bit timer). The other overflow is ignored.
- R3: `busy_o` rises at the clock edge that accepts a start and stays 1 until the conversion completes. Start events that arrive while `busy_o` is 1 are ignored and do not start a second conversion.
- R4: Tracking mode 10 (pre), and reserved mode 00 treated the same way, issues `conv_start_o` in the first cycle after the accepting edge. `trk_en_o` is 1 whenever the sequencer is idle.
- R5: Tracking mode 01 (post) holds `trk_en_o` at 1 for (`trk_time_i`+1)×4 cycles after the accepting edge, then pulses `conv_start_o`. After completion, and while idle before the first start, `trk_en_o` is 0.
- R6: Tracking mode 11 (dual) has the same timed window as R5. After completion `trk_en_o` returns to 1 and stays there while idle.
- R7: `conv_start_o` is a one-cycle pulse with `busy_o` at 1, and `trk_en_o` is 0 for the whole conversion phase.
- R8: `conv_done_i` during conversion clears `busy_o`, sets `cmp_flag_o` and loads `conv_data_i` into `result_o`, all at the same edge. `conv_done_i` at any other time has no effect on `result_o` or `cmp_flag_o`.
- R9: `cmp_flag_o` stays at 1 until an `int_clr_i` pulse clears it. A completion in the same cycle as a clear leaves it at 1. `irq_o` is 1 exactly when `cmp_flag_o` and `int_en_i` are both 1.
- R10: After reset, `busy_o`, `conv_start_o`, `cmp_flag_o` and `irq_o` are 0 and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_src_i | input | 2 | Start source select |
| trk_mode_i | input | 2 | Tracking policy select |
| trk_time_i | input | 2 | Tracking window length code |
| t2_byte_mode_i | input | 1 | 1 = timer 2 in 8-bit mode |
| sw_busy_wr_i | input | 1 | Pulse: software writes 1 to busy |
| cnv_pin_i | input | 1 | Asynchronous external start pin |
| t1_ovf_i | input | 1 | Timer-1 overflow pulse |
| t2_lo_ovf_i | input | 1 | Timer-2 low-byte overflow pulse |
| t2_hi_ovf_i | input | 1 | Timer-2 high-byte overflow pulse |
| int_en_i | input | 1 | Interrupt enable |
| int_clr_i | input | 1 | Pulse: software clears completion flag |
| conv_done_i | input | 1 | Converter done handshake |
| conv_data_i | input | 12 | Converter result data |
| trk_en_o | output | 1 | Sample switch closed (tracking) |
| conv_start_o | output | 1 | One-cycle convert strobe |
| busy_o | output | 1 | Conversion in progress |
| cmp_flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |
| result_o | output | 12 | Latched conversion result |

## Verification
A wrong phase register shows within one cycle: `busy_o` and `trk_en_o` disagree with the policy, or `conv_start_o` fires twice. A wrong tracking counter moves the cycle in which `conv_start_o` appears by at least one cycle, and the bench measures this exactly for every window length it uses. A faulty source decode or synchronizer shows as a start that is missing, comes late, or comes from the wrong pulse, within the same vector. Flag and result errors show in the cycle after the done handshake.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_TRACK = 2'd1,
      PH_CONV  = 2'd2
   } seq_phase_e;

   localparam logic [1:0] SRC_SOFT  = 2'b00;
   localparam logic [1:0] SRC_PIN   = 2'b01;
   localparam logic [1:0] SRC_TMR1  = 2'b10;
   localparam logic [1:0] SRC_TMR2  = 2'b11;

   // timed window before conversion: post (01) and dual (11)
   function automatic logic mode_has_window(input logic [1:0] m);
      return m[0];
   endfunction

   // switch closed while idle: pre (10), dual (11), reserved (00)
   function automatic logic mode_idle_tracks(input logic [1:0] m);
      return m[1] | ~m[0];
   endfunction

endpackage

// File: rtl/adc_start_sel.sv
module adc_start_sel #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] src_i,
   input  logic       sw_wr_i,
   input  logic       pin_i,
   input  logic       t1_ovf_i,
   input  logic       t2_lo_i,
   input  logic       t2_hi_i,
   input  logic       t2_byte_i,
   output logic       evt_o
);
   import adc_seq_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("adc_start_sel: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   pin_rise;
   logic                   t2_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign pin_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
   assign t2_evt   = t2_byte_i ? t2_lo_i : t2_hi_i;

   always_comb begin
      unique case (src_i)
         SRC_SOFT: evt_o = sw_wr_i;
         SRC_PIN:  evt_o = pin_rise;
         SRC_TMR1: evt_o = t1_ovf_i;
         default:  evt_o = t2_evt;
      endcase
   end

endmodule

// File: rtl/adc_trk_timer.sv
module adc_trk_timer #(
   parameter int TT_W    = 2,
   parameter int TT_UNIT = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [TT_W-1:0] tt_i,
   output logic            expired_o
);
   localparam int MAX_TICKS = (2 ** TT_W) * TT_UNIT;
   localparam int CNT_W     = $clog2(MAX_TICKS);

   generate
      if (TT_W < 1 || TT_UNIT < 1) begin : g_bad_cfg
         $error("adc_trk_timer: TT_W and TT_UNIT must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;
   int unsigned      ticks;

   always_comb begin
      ticks    = (int'(tt_i) + 1) * TT_UNIT;
      load_val = CNT_W'(ticks - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/adc_trk_seq.sv
module adc_trk_seq #(
   parameter int RES_W       = 12,
   parameter int TT_W        = 2,
   parameter int TT_UNIT     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       start_src_i,
   input  logic [1:0]       trk_mode_i,
   input  logic [TT_W-1:0]  trk_time_i,
   input  logic             t2_byte_mode_i,
   input  logic             sw_busy_wr_i,
   input  logic             cnv_pin_i,
   input  logic             t1_ovf_i,
   input  logic             t2_lo_ovf_i,
   input  logic             t2_hi_ovf_i,
   input  logic             int_en_i,
   input  logic             int_clr_i,
   input  logic             conv_done_i,
   input  logic [RES_W-1:0] conv_data_i,
   output logic             trk_en_o,
   output logic             conv_start_o,
   output logic             busy_o,
   output logic             cmp_flag_o,
   output logic             irq_o,
   output logic [RES_W-1:0] result_o
);
   import adc_seq_pkg::*;

   generate
      if (RES_W < 1) begin : g_bad_res
         $error("adc_trk_seq: RES_W must be positive");
      end
   endgenerate

   seq_phase_e       phase_q, phase_d;
   logic             start_evt;
   logic             win_load;
   logic             win_done;
   logic             enter_conv;
   logic             finish;
   logic             strobe_q;
   logic             flag_q;
   logic [RES_W-1:0] res_q;

   adc_start_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (start_src_i),
      .sw_wr_i   (sw_busy_wr_i),
      .pin_i     (cnv_pin_i),
      .t1_ovf_i  (t1_ovf_i),
      .t2_lo_i   (t2_lo_ovf_i),
      .t2_hi_i   (t2_hi_ovf_i),
      .t2_byte_i (t2_byte_mode_i),
      .evt_o     (start_evt)
   );

   adc_trk_timer #(.TT_W(TT_W), .TT_UNIT(TT_UNIT)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (win_load),
      .tt_i      (trk_time_i),
      .expired_o (win_done)
   );

   always_comb begin
      phase_d    = phase_q;
      win_load   = 1'b0;
      enter_conv = 1'b0;
      finish     = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start_evt) begin
               if (mode_has_window(trk_mode_i)) begin
                  phase_d  = PH_TRACK;
                  win_load = 1'b1;
               end else begin
                  phase_d    = PH_CONV;
                  enter_conv = 1'b1;
               end
            end
         end
         PH_TRACK: begin
            if (win_done) begin
               phase_d    = PH_CONV;
               enter_conv = 1'b1;
            end
         end
         default: begin
            if (conv_done_i) begin
               phase_d = PH_IDLE;
               finish  = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         strobe_q <= 1'b0;
         flag_q   <= 1'b0;
         res_q    <= '0;
      end else begin
         phase_q  <= phase_d;
         strobe_q <= enter_conv;
         if (finish) begin
            flag_q <= 1'b1;
            res_q  <= conv_data_i;
         end else if (int_clr_i) begin
            flag_q <= 1'b0;
         end
      end
   end

   always_comb begin
      unique case (phase_q)
         PH_IDLE:  trk_en_o = mode_idle_tracks(trk_mode_i);
         PH_TRACK: trk_en_o = 1'b1;
         default:  trk_en_o = 1'b0;
      endcase
   end

   assign conv_start_o = strobe_q;
   assign busy_o       = (phase_q != PH_IDLE);
   assign cmp_flag_o   = flag_q;
   assign irq_o        = flag_q & int_en_i;
   assign result_o     = res_q;

endmodule

// File: rtl/adc_trk_seq_chk.sv
module adc_trk_seq_chk #(
   parameter int RES_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       trk_mode_i,
   input logic             int_clr_i,
   input logic             trk_en_o,
   input logic             conv_start_o,
   input logic             busy_o,
   input logic             cmp_flag_o,
   input logic [RES_W-1:0] result_o
);

   assert_flag_on_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> cmp_flag_o);

   assert_flag_rise_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_flag_o) |-> $fell(busy_o));

   assert_result_moves_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_o) |-> $fell(busy_o));

   assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |=> !conv_start_o);

   assert_strobe_while_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> (busy_o && !trk_en_o));

   assert_pre_starts_at_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_o) && !$past(trk_mode_i[0])) |-> conv_start_o);

   assert_post_open_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && trk_mode_i == 2'b01) |-> !trk_en_o);

   assert_dual_tracks_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && trk_mode_i == 2'b11) |-> trk_en_o);

   assert_flag_clear_by_sw_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmp_flag_o) |-> $past(int_clr_i));

endmodule

bind adc_trk_seq adc_trk_seq_chk #(.RES_W(RES_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .trk_mode_i   (trk_mode_i),
   .int_clr_i    (int_clr_i),
   .trk_en_o     (trk_en_o),
   .conv_start_o (conv_start_o),
   .busy_o       (busy_o),
   .cmp_flag_o   (cmp_flag_o),
   .result_o     (result_o)
);

// File: tb/adc_trk_seq_tb_top.sv
module adc_trk_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RES_W      = 12;
   localparam logic [5:0] NONE = 6'd63;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       start_src_i = 2'b00;
   logic [1:0]       trk_mode_i = 2'b10;
   logic [1:0]       trk_time_i = 2'b00;
   logic             t2_byte_mode_i = 1'b0;
   logic             sw_busy_wr_i = 1'b0;
   logic             cnv_pin_i = 1'b0;
   logic             t1_ovf_i = 1'b0;
   logic             t2_lo_ovf_i = 1'b0;
   logic             t2_hi_ovf_i = 1'b0;
   logic             int_en_i = 1'b0;
   logic             int_clr_i = 1'b0;
   logic             conv_done_i = 1'b0;
   logic [RES_W-1:0] conv_data_i = '0;
   logic             trk_en_o, conv_start_o, busy_o, cmp_flag_o, irq_o;
   logic [RES_W-1:0] result_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_trk_seq #(.RES_W(RES_W)) dut_i (.*);

   // kind: 0 sw, 1 pin, 2 t1, 3 t2 low, 4 t2 high
   typedef struct packed {
      logic [2:0] kind;
      logic [1:0] src;
      logic [1:0] mode;
      logic [1:0] tt;
      logic       split;
      logic [5:0] exp_cnt;
      logic       after;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 2'b00, 2'b10, 2'd0, 1'b0, 6'd0,  1'b1},  // R4 pre
      '{3'd0, 2'b00, 2'b00, 2'd0, 1'b0, 6'd0,  1'b1},  // R4 reserved
      '{3'd0, 2'b00, 2'b01, 2'd0, 1'b0, 6'd4,  1'b0},  // R5 post
      '{3'd0, 2'b00, 2'b01, 2'd3, 1'b0, 6'd16, 1'b0},  // R5 longest
      '{3'd0, 2'b00, 2'b11, 2'd1, 1'b0, 6'd8,  1'b1},  // R6 dual
      '{3'd1, 2'b01, 2'b10, 2'd0, 1'b0, 6'd2,  1'b1},  // R1 pin
      '{3'd2, 2'b10, 2'b11, 2'd2, 1'b0, 6'd12, 1'b1},  // R1 t1
      '{3'd3, 2'b11, 2'b10, 2'd0, 1'b1, 6'd0,  1'b1},  // R2 low byte
      '{3'd4, 2'b11, 2'b01, 2'd0, 1'b0, 6'd4,  1'b0},  // R2 high byte
      '{3'd4, 2'b11, 2'b10, 2'd0, 1'b1, NONE,  1'b1},  // R2 ignored
      '{3'd3, 2'b11, 2'b10, 2'd0, 1'b0, NONE,  1'b1},  // R2 ignored
      '{3'd2, 2'b00, 2'b10, 2'd0, 1'b0, NONE,  1'b1},  // R1 ignored
      '{3'd0, 2'b10, 2'b10, 2'd0, 1'b0, NONE,  1'b1},  // R1 ignored
      '{3'd1, 2'b00, 2'b10, 2'd0, 1'b0, NONE,  1'b1}   // R1 ignored
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic fire(input int kind);
      case (kind)
         0: sw_busy_wr_i = 1'b1;
         1: cnv_pin_i    = 1'b1;
         2: t1_ovf_i     = 1'b1;
         3: t2_lo_ovf_i  = 1'b1;
         default: t2_hi_ovf_i = 1'b1;
      endcase
   endtask

   task automatic drop_pulses();
      sw_busy_wr_i = 1'b0;
      t1_ovf_i     = 1'b0;
      t2_lo_ovf_i  = 1'b0;
      t2_hi_ovf_i  = 1'b0;
   endtask

   // counts cycles to conv_start; refire_at >= 0 re-issues sw during track
   task automatic measure(output int cnt, output bit seen, output bit trk_ok,
                          input int refire_at);
      cnt = 0; seen = 1'b0; trk_ok = 1'b1;
      for (int i = 0; i < 40 && !seen; i++) begin
         @(negedge clk);
         drop_pulses();
         if (conv_start_o) seen = 1'b1;
         else begin
            if (busy_o && !trk_en_o) trk_ok = 1'b0;
            cnt++;
            if (i == refire_at) sw_busy_wr_i = 1'b1;
         end
      end
   endtask

   task automatic clear_flag();
      int_clr_i = 1'b1;
      @(negedge clk);
      int_clr_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int cnt; bit seen; bit trk_ok;
      logic [RES_W-1:0] last_res;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(!busy_o && !conv_start_o && !cmp_flag_o && !irq_o, "R10 flags", busy_o, 0);
      chk(result_o == '0, "R10 result", result_o, 0);
      chk(trk_en_o == 1'b1, "R4 idle tracks", trk_en_o, 1);
      trk_mode_i = 2'b01; #1;
      chk(trk_en_o == 1'b0, "R5 idle open before first start", trk_en_o, 0);
      trk_mode_i = 2'b11; #1;
      chk(trk_en_o == 1'b1, "R6 idle tracks", trk_en_o, 1);

      last_res = '0;
      for (int v = 0; v < NV; v++) begin
         logic [RES_W-1:0] data;
         data = RES_W'(12'hA50 + v);
         start_src_i    = VECS[v].src;
         trk_mode_i     = VECS[v].mode;
         trk_time_i     = VECS[v].tt;
         t2_byte_mode_i = VECS[v].split;
         @(negedge clk);
         fire(int'(VECS[v].kind));
         measure(cnt, seen, trk_ok, -1);
         if (VECS[v].exp_cnt == NONE) begin
            chk(!seen && !busy_o, "R1/R2 unselected source ignored", int'(seen), 0);
            chk(result_o == last_res, "R1/R2 result untouched", result_o, last_res);
         end else begin
            chk(seen && cnt == int'(VECS[v].exp_cnt), "R1/R2/R4/R5/R6 start latency",
                cnt, int'(VECS[v].exp_cnt));
            chk(trk_ok, "R5/R6 tracking during window", int'(trk_ok), 1);
            chk(!trk_en_o && busy_o, "R7 switch open while converting", trk_en_o, 0);
            conv_done_i = 1'b1;
            conv_data_i = data;
            @(negedge clk);
            conv_done_i = 1'b0;
            chk(!busy_o && cmp_flag_o, "R8 busy clears and flag sets", busy_o, 0);
            chk(result_o == data, "R8 result latched", result_o, data);
            chk(trk_en_o == VECS[v].after, "R4/R5/R6 switch after conversion",
                trk_en_o, VECS[v].after);
            last_res = data;
            clear_flag();
         end
         cnv_pin_i = 1'b0;
         repeat (4) @(negedge clk);
      end

      // R8 done outside conversion ignored
      conv_done_i = 1'b1; conv_data_i = 12'h123;
      @(negedge clk);
      conv_done_i = 1'b0;
      @(negedge clk);
      chk(result_o == last_res && !cmp_flag_o, "R8 stray done ignored", result_o, last_res);

      // R3 starts ignored while busy
      start_src_i = 2'b00; trk_mode_i = 2'b01; trk_time_i = 2'd3;
      @(negedge clk);
      fire(0);
      measure(cnt, seen, trk_ok, 5);
      chk(seen && cnt == 16, "R3 restart during window ignored", cnt, 16);
      sw_busy_wr_i = 1'b1;
      @(negedge clk);
      sw_busy_wr_i = 1'b0;
      chk(busy_o && !conv_start_o, "R3 restart during conversion ignored", conv_start_o, 0);
      conv_done_i = 1'b1; conv_data_i = 12'h5C3;
      @(negedge clk);
      conv_done_i = 1'b0;
      chk(!busy_o && cmp_flag_o, "R3 busy clears on completion", busy_o, 0);
      repeat (3) @(negedge clk);
      chk(!busy_o, "R3 no second conversion", busy_o, 0);

      // R9 flag hold and interrupt gating
      chk(cmp_flag_o && !irq_o, "R9 irq masked", irq_o, 0);
      int_en_i = 1'b1; #1;
      chk(irq_o, "R9 irq enabled", irq_o, 1);
      repeat (5) @(negedge clk);
      chk(cmp_flag_o, "R9 flag held", cmp_flag_o, 1);
      clear_flag();
      chk(!cmp_flag_o && !irq_o, "R9 flag cleared", cmp_flag_o, 0);

      // R9 completion wins over clear
      trk_mode_i = 2'b10;
      @(negedge clk);
      fire(0);
      measure(cnt, seen, trk_ok, -1);
      conv_done_i = 1'b1; int_clr_i = 1'b1; conv_data_i = 12'h0F0;
      @(negedge clk);
      conv_done_i = 1'b0; int_clr_i = 1'b0;
      chk(seen && cmp_flag_o && irq_o, "R9 set wins over clear", cmp_flag_o, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule